// File: doc/BRIEF.md
# Hybrid Shift-Register / Cellular-Automaton Uniform Random Word Generator

This block produces one 32-bit pseudo-random word per enabled clock. It holds two independent state registers. One is a 43-bit linear feedback shift register with an XOR feedback. The other is a ring of 37 cells that evolves by a nonlinear neighbourhood rule. All cells and the shift register advance in the same clock edge. The output word is the bitwise XOR of the low 32 bits of the two freshly advanced states. Mixing a linear sequence with a nonlinear one hides the linear structure that a bare shift register shows.

Software or a controlling block seeds both registers at once through a single seed bus and a load strobe. An all-zero seed for the shift register part would lock it up, so it is replaced by a fixed nonzero constant. The enable input gates the advance. While it is low, nothing moves and the valid flag is low. A downstream consumer takes a word in every cycle in which the valid flag is high.

Top module: `hybrid_urng`

## Requirements
- R1: In the cycle after a clock edge where `en_i` is 1 and `load_i` is 0, `valid_o` is 1. `rnd_o` then equals bits [31:0] of the advanced shift register XOR bits [31:0] of the advanced cell ring.
- R2: Each advance of the 43-bit shift register moves it one place toward the MSB. The new bit 0 is the XOR of the old bits 42, 41, 37 and 36.
- R3: Each advance of the 37-cell ring sets every cell i to old cell (i-1) XOR (old cell i OR old cell (i+1)). Indices wrap modulo 37, and all cells update on the same edge.
- R4: When `load_i` is 1 at an edge, the shift register takes `seed_i[42:0]` and the ring takes `seed_i[79:43]`. Load wins over `en_i`. `valid_o` is 0 in the following cycle and `rnd_o` keeps its value.
- R5: A load whose `seed_i[42:0]` is zero puts the constant 43'h2B3C4D5E6F7 into the shift register instead.
- R6: When `en_i` and `load_i` are both 0 at an edge, both registers and `rnd_o` hold their values, and `valid_o` is 0.
- R7: With `rst_n` low at an edge (synchronous, active low), the shift register becomes 43'h2B3C4D5E6F7. The ring becomes 1 in cell 0 only, `rnd_o` becomes 0 and `valid_o` becomes 0.
- R8: The shift register state is never all zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Advance both registers and emit a word |
| load_i | input | 1 | Load both registers from `seed_i` |
| seed_i | input | 80 | Bits [42:0] seed the shift register, bits [79:43] seed the ring |
| rnd_o | output | 32 | Output random word |
| valid_o | output | 1 | `rnd_o` holds a fresh word this cycle |

## Verification
The bench builds the block with its default sizes: a 43-bit shift register, a 37-cell ring and a 32-bit word. These sizes are small enough that a bit-exact arithmetic model of both registers runs beside the design. Every output word is compared for more than twenty thousand cycles. The runs cover a long uninterrupted sequence from reset and several random seeds under randomly gated enable. They also cover a load during enable, an all-zero seed that must take the substitute constant, and a reset in mid-run.

// File: rtl/urng_pkg.sv
// Package: shared defaults for the hybrid uniform random word generator.
// Assumes: the tap set below is a maximal-length polynomial for 43 bits.
package urng_pkg;
    localparam int unsigned URNG_LFSR_W = 43;
    localparam int unsigned URNG_CA_K   = 37;
    localparam int unsigned URNG_OUT_W  = 32;
    // feedback taps at bits 42, 41, 37, 36
    localparam logic [URNG_LFSR_W-1:0] URNG_TAPS     = 43'h630_0000_0000;
    // substitute for an all-zero shift register seed
    localparam logic [URNG_LFSR_W-1:0] URNG_ZERO_FIX = 43'h2B3_C4D5_E6F7;
endpackage

// File: rtl/urng_lfsr.sv
// Module: Fibonacci shift register that moves toward the MSB and feeds the XOR
// of the tapped bits back into bit 0. Exposes the full state for checking and
// the low OUT_W bits of the next state for output mixing.
// Assumes: ZERO_FIX is nonzero; OUT_W <= W.
module urng_lfsr #(
    parameter int unsigned W     = 43,
    parameter int unsigned OUT_W = 32,
    parameter logic [W-1:0] TAPS     = '1,
    parameter logic [W-1:0] ZERO_FIX = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [W-1:0]     seed_i,
    output logic [W-1:0]     state_o,
    output logic [OUT_W-1:0] next_low_o
);
    logic [W-1:0] state_q;
    logic [W-1:0] state_nx;
    logic         fb;

    // feedback bit and shifted next state
    always_comb begin
        fb       = ^(state_q & TAPS);
        state_nx = {state_q[W-2:0], fb};
    end

    // state register: reset, seed load with zero substitution, or advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ZERO_FIX;
        end else if (load_i) begin
            state_q <= (seed_i == '0) ? ZERO_FIX : seed_i;
        end else if (step_i) begin
            state_q <= state_nx;
        end
    end

    assign state_o    = state_q;
    assign next_low_o = state_nx[OUT_W-1:0];
endmodule

// File: rtl/urng_ca.sv
// Module: ring of K binary cells. Every cell takes
// left XOR (self OR right) on the same edge, with wrap-around.
// Assumes: K >= 3; OUT_W <= K.
module urng_ca #(
    parameter int unsigned K     = 37,
    parameter int unsigned OUT_W = 32,
    parameter logic [K-1:0] INIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [K-1:0]     seed_i,
    output logic [K-1:0]     state_o,
    output logic [OUT_W-1:0] next_low_o
);
    logic [K-1:0] cell_q;
    logic [K-1:0] cell_nx;

    // per-cell neighbourhood rule
    for (genvar gi = 0; gi < K; gi++) begin : g_cell
        localparam int unsigned LEFT  = (gi + K - 1) % K;
        localparam int unsigned RIGHT = (gi + 1) % K;
        assign cell_nx[gi] = cell_q[LEFT] ^ (cell_q[gi] | cell_q[RIGHT]);
    end

    // ring register: reset, seed load, or synchronous advance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_q <= INIT;
        end else if (load_i) begin
            cell_q <= seed_i;
        end else if (step_i) begin
            cell_q <= cell_nx;
        end
    end

    assign state_o    = cell_q;
    assign next_low_o = cell_nx[OUT_W-1:0];
endmodule

// File: rtl/urng_mix.sv
// Module: output stage. Registers the XOR of the two next-state slices when an
// advance happens, and flags the word valid for exactly that cycle.
// Assumes: load has priority over step, as in the state registers.
module urng_mix #(
    parameter int unsigned OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [OUT_W-1:0] lin_i,
    input  logic [OUT_W-1:0] ca_i,
    output logic [OUT_W-1:0] rnd_o,
    output logic             valid_o
);
    logic adv;

    // an advance happens only when enabled and not loading
    assign adv = step_i & ~load_i;

    // output word and valid flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rnd_o   <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= adv;
            if (adv) begin
                rnd_o <= lin_i ^ ca_i;
            end
        end
    end
endmodule

// File: rtl/hybrid_urng.sv
// Module: top of the hybrid uniform random word generator. Ties the shift
// register, the cell ring and the output stage to a shared load and enable.
// Assumes: OUT_W does not exceed either register width.
module hybrid_urng
    import urng_pkg::*;
#(
    parameter int unsigned LFSR_W = URNG_LFSR_W,
    parameter int unsigned CA_K   = URNG_CA_K,
    parameter int unsigned OUT_W  = URNG_OUT_W,
    parameter logic [LFSR_W-1:0] LFSR_TAPS = URNG_TAPS,
    parameter logic [LFSR_W-1:0] ZERO_FIX  = URNG_ZERO_FIX,
    parameter logic [CA_K-1:0]   CA_INIT   = {{(CA_K-1){1'b0}}, 1'b1},
    localparam int unsigned SEED_W = LFSR_W + CA_K
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              load_i,
    input  logic [SEED_W-1:0] seed_i,
    output logic [OUT_W-1:0]  rnd_o,
    output logic              valid_o
);
    logic [LFSR_W-1:0] lfsr_state;
    logic [CA_K-1:0]   ca_state;
    logic [OUT_W-1:0]  lfsr_low;
    logic [OUT_W-1:0]  ca_low;

    urng_lfsr #(
        .W(LFSR_W), .OUT_W(OUT_W), .TAPS(LFSR_TAPS), .ZERO_FIX(ZERO_FIX)
    ) u_lfsr (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(en_i),
        .seed_i(seed_i[LFSR_W-1:0]), .state_o(lfsr_state), .next_low_o(lfsr_low)
    );

    urng_ca #(
        .K(CA_K), .OUT_W(OUT_W), .INIT(CA_INIT)
    ) u_ca (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(en_i),
        .seed_i(seed_i[SEED_W-1:LFSR_W]), .state_o(ca_state), .next_low_o(ca_low)
    );

    urng_mix #(
        .OUT_W(OUT_W)
    ) u_mix (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(en_i),
        .lin_i(lfsr_low), .ca_i(ca_low), .rnd_o(rnd_o), .valid_o(valid_o)
    );
endmodule

// File: rtl/hybrid_urng_chk.sv
// Module: property checker for hybrid_urng, attached by bind below.
// Assumes: reset is synchronous and active low.
module hybrid_urng_chk #(
    parameter int unsigned LFSR_W = 43,
    parameter int unsigned CA_K   = 37,
    parameter int unsigned OUT_W  = 32,
    parameter logic [LFSR_W-1:0] ZERO_FIX = 1,
    localparam int unsigned SEED_W = LFSR_W + CA_K
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_i,
    input logic              load_i,
    input logic [SEED_W-1:0] seed_i,
    input logic [OUT_W-1:0]  rnd_o,
    input logic              valid_o,
    input logic [LFSR_W-1:0] lfsr_state,
    input logic [CA_K-1:0]   ca_state
);
    AST_VALID_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i) |=> valid_o); // R1
    AST_OUT_IS_MIX: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (rnd_o == (lfsr_state[OUT_W-1:0] ^ ca_state[OUT_W-1:0]))); // R1
    AST_LFSR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i) |=> (lfsr_state[LFSR_W-1:1] == $past(lfsr_state[LFSR_W-2:0]))); // R2
    AST_CA_CELL0: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !load_i) |=> (ca_state[0] ==
            ($past(ca_state[CA_K-1]) ^ ($past(ca_state[0]) | $past(ca_state[1]))))); // R3
    AST_LOAD_RING: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> ((ca_state == $past(seed_i[SEED_W-1:LFSR_W])) && !valid_o && $stable(rnd_o))); // R4
    AST_ZERO_SEED_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && (seed_i[LFSR_W-1:0] == '0)) |=> (lfsr_state == ZERO_FIX)); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !load_i) |=> ($stable(lfsr_state) && $stable(ca_state)
                                && $stable(rnd_o) && !valid_o)); // R6
    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != '0); // R8
endmodule

bind hybrid_urng hybrid_urng_chk #(
    .LFSR_W(LFSR_W), .CA_K(CA_K), .OUT_W(OUT_W), .ZERO_FIX(ZERO_FIX)
) u_chk (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .load_i(load_i), .seed_i(seed_i),
    .rnd_o(rnd_o), .valid_o(valid_o), .lfsr_state(lfsr_state), .ca_state(ca_state)
);

// File: tb/hybrid_urng_tb.sv
// Bench: bit-exact arithmetic model of both registers, compared every cycle.
module hybrid_urng_tb;
    localparam int SW = 80;
    localparam logic [42:0] FIX = 43'h2B3C4D5E6F7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b0;
    logic          load = 1'b0;
    logic [SW-1:0] seed = '0;
    logic [31:0]   rnd;
    logic          valid;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    logic [42:0] ml;
    logic [36:0] mc;
    logic [31:0] mo;
    logic        mv;

    always #5 clk = ~clk;

    hybrid_urng u_dut (
        .clk(clk), .rst_n(rst_n), .en_i(en), .load_i(load), .seed_i(seed),
        .rnd_o(rnd), .valid_o(valid)
    );

    // R2: shift toward MSB, bit 0 = xor of bits 42, 41, 37, 36
    function automatic logic [42:0] lnext(input logic [42:0] s);
        return {s[41:0], s[42] ^ s[41] ^ s[37] ^ s[36]};
    endfunction

    // R3: cell i = left xor (self or right), ring of 37
    function automatic logic [36:0] cnext(input logic [36:0] a);
        logic [36:0] r;
        for (int i = 0; i < 37; i++) r[i] = a[(i + 36) % 37] ^ (a[i] | a[(i + 1) % 37]);
        return r;
    endfunction

    task automatic check(input string tag);
        vectors++;
        if (rnd !== mo || valid !== mv) begin
            miscompares++;
            $display("FAIL %s: rnd=%h valid=%b expected rnd=%h valid=%b", tag, rnd, valid, mo, mv);
        end
    endtask

    task automatic step(input logic e, input logic l, input logic [SW-1:0] s, input string tag);
        en = e; load = l; seed = s;
        @(posedge clk); #2;
        if (l) begin
            ml = (s[42:0] == '0) ? FIX : s[42:0];
            mc = s[79:43];
            mv = 1'b0;
        end else if (e) begin
            ml = lnext(ml);
            mc = cnext(mc);
            mo = ml[31:0] ^ mc[31:0];
            mv = 1'b1;
        end else begin
            mv = 1'b0;
        end
        check(tag);
    endtask

    task automatic do_reset(input string tag);
        rst_n = 1'b0; en = 1'b0; load = 1'b0;
        repeat (2) @(posedge clk);
        #2;
        ml = FIX; mc = 37'h1; mo = '0; mv = 1'b0;
        check(tag);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [95:0] w;
        do_reset("R7 reset state");
        // long enabled run from the reset state
        for (int n = 0; n < 10000; n++) step(1'b1, 1'b0, '0, "R1 R2 R3 free run");
        // seeded runs with gated enable; load issued with enable high
        for (int k = 0; k < 8; k++) begin
            w = {$urandom(), $urandom(), $urandom()};
            if (k == 0) w[42:0] = '0;
            step(1'b1, 1'b1, w[79:0], (k == 0) ? "R4 R5 load zero shift seed" : "R4 load seed");
            for (int n = 0; n < 1200; n++) begin
                if (($urandom() % 4) != 0) step(1'b1, 1'b0, '0, "R1 R2 R3 seeded");
                else step(1'b0, 1'b0, '0, "R6 hold");
            end
        end
        // fully zero seed: substitute constant, never locks
        step(1'b0, 1'b1, '0, "R5 zero seed load");
        for (int n = 0; n < 500; n++) step(1'b1, 1'b0, '0, "R5 R8 after zero seed");
        // reset in mid-run, then continue
        do_reset("R7 reset mid-run");
        for (int n = 0; n < 50; n++) step(1'b1, 1'b0, '0, "R7 R1 after reset");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            miscompares++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule